// File: doc/BRIEF.md
# Quarter-Squares Unsigned Multiplier

This block multiplies two unsigned operands of `OP_W` bits (8 by default) without a partial-product array. It uses the identity that the product of two numbers is the square of their half-sum minus the square of their half-difference. In integer form, it takes the square of the sum, subtracts the square of the absolute difference, and drops the two low bits of the result. Both squares come from tables that are computed while the design elaborates, so no memory image has to be loaded.

The block is purely combinational. The operand ordering logic compares the two inputs and sends a small strobe struct to the datapath. That struct tells the datapath which operand is the larger, so that the difference is never negative. The datapath then forms the sum and the magnitude of the difference and performs the two table lookups. A final subtract and a two-bit shift produce the `2*OP_W`-bit product. The result appears at the output in the same evaluation as the inputs change.

Top module: `quarter_square_mult`

## Requirements
- R1: For unsigned operands `opA` and `opB`, `product` equals `opA*opB` as a `2*OP_W`-bit unsigned value, for every operand pair.
- R2: When either operand is zero, `product` is zero, whatever the other operand holds.
- R3: When both operands are equal, `product` equals the square of that operand. The difference term is zero in this case.
- R4: Swapping the operands leaves `product` unchanged. The difference term uses the larger operand minus the smaller, so its sign never depends on input order.
- R5: With both operands at their maximum value `2^OP_W-1`, `product` equals `(2^OP_W-1)^2`, with no truncation. The sum-square table covers indices 0 to `2^(OP_W+1)-2`.
- R6: When one operand equals 1, `product` equals the other operand, zero-extended.
- R7: `product` follows a change of the operands with no clock edge involved. There is no register and no reset inside the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | OP_W | First unsigned operand |
| opB | input | OP_W | Second unsigned operand |
| product | output | 2*OP_W | Unsigned product of the two operands |

## Verification
The main function is first tried exhaustively over all 65536 operand pairs at the default width, compared against the language's own multiply. This separates a correct table and shift from any single wrong table entry or an off-by-one in the index range. A short vector table then covers zero operands, which show whether the difference lookup cancels the sum lookup exactly. Equal operands isolate the zero-difference path. Mirrored pairs expose a wrong ordering decision, and the all-ones pair checks the top table entry and the width of the final subtract. A last test changes the inputs between clock edges, to show that the output follows without any register.

// File: rtl/qsq_pkg.sv
package qsq_pkg;

  // Strobes sent from the ordering logic to the datapath.
  typedef struct packed {
    logic swapOps;   // opB is strictly larger than opA
    logic zeroDiff;  // operands are equal, difference term is zero
  } qsqCtl_t;

endpackage

// File: rtl/qsq_square_table.sv
// Table of squares filled at elaboration time; one lookup port.
module qsq_square_table #(
  parameter int IDX_W   = 9,
  parameter int MAX_IDX = 510,
  parameter int SQ_W    = 18
) (
  input  logic [IDX_W-1:0] idx,
  output logic [SQ_W-1:0]  sq
);

  localparam int DEPTH = MAX_IDX + 1;

  logic [SQ_W-1:0] tableMem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign tableMem[i] = SQ_W'(i * i);
  end

  always_comb begin
    if (32'(idx) <= MAX_IDX) sq = tableMem[idx];
    else                     sq = '0;
  end

endmodule

// File: rtl/qsq_order_ctl.sv
// Decides which operand is larger and whether they are equal.
module qsq_order_ctl
  import qsq_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output qsqCtl_t         ctl
);

  always_comb begin
    ctl.swapOps  = (opB > opA);
    ctl.zeroDiff = (opA == opB);
  end

endmodule

// File: rtl/qsq_datapath.sv
// Sum, absolute difference, two square lookups, subtract and shift.
module qsq_datapath
  import qsq_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  qsqCtl_t           ctl,
  output logic [2*OP_W-1:0] product
);

  localparam int SUM_W      = OP_W + 1;
  localparam int SUM_SQ_W   = 2 * SUM_W;
  localparam int DIFF_SQ_W  = 2 * OP_W;
  localparam int SUM_MAX    = (2 ** SUM_W) - 2;
  localparam int DIFF_MAX   = (2 ** OP_W) - 1;

  logic [OP_W-1:0]      bigOp;
  logic [OP_W-1:0]      smallOp;
  logic [OP_W-1:0]      absDiff;
  logic [SUM_W-1:0]     sumIdx;
  logic [SUM_SQ_W-1:0]  sumSq;
  logic [DIFF_SQ_W-1:0] diffSq;
  logic [SUM_SQ_W-1:0]  sqGap;

  always_comb begin
    bigOp   = ctl.swapOps ? opB : opA;
    smallOp = ctl.swapOps ? opA : opB;
    absDiff = bigOp - smallOp;
    sumIdx  = {1'b0, opA} + {1'b0, opB};
  end

  qsq_square_table #(
    .IDX_W  (SUM_W),
    .MAX_IDX(SUM_MAX),
    .SQ_W   (SUM_SQ_W)
  ) u_sumTable (
    .idx(sumIdx),
    .sq (sumSq)
  );

  qsq_square_table #(
    .IDX_W  (OP_W),
    .MAX_IDX(DIFF_MAX),
    .SQ_W   (DIFF_SQ_W)
  ) u_diffTable (
    .idx(absDiff),
    .sq (diffSq)
  );

  always_comb begin
    sqGap   = sumSq - {2'b00, diffSq};
    product = sqGap[SUM_SQ_W-1:2];
  end

  // Checks on signals driven by separate pieces of logic.
  always_comb begin
    // R1: the difference square never exceeds the sum square and the gap is a multiple of four
    assert_gap_exact_R1: assert ((SUM_SQ_W'(diffSq) <= sumSq) && (sqGap[1:0] == 2'b00))
      else $error("square gap not exact");
    // R4: magnitude of the difference bounded by both operands' maximum
    assert_diff_bounded_R4: assert ((absDiff <= opA) || (absDiff <= opB))
      else $error("difference exceeds operands");
    // R1: sum and difference have the same parity
    assert_same_parity_R1: assert (sumIdx[0] == absDiff[0])
      else $error("sum and difference parity differ");
    // R3: equal operands give a zero difference square
    assert_zero_diff_R3: assert (!ctl.zeroDiff || (diffSq == '0))
      else $error("equal operands gave nonzero difference square");
    // R2: a zero operand makes both squares equal
    assert_zero_operand_R2: assert (!((opA == '0) || (opB == '0)) || (SUM_SQ_W'(diffSq) == sumSq))
      else $error("zero operand did not cancel squares");
  end

endmodule

// File: rtl/quarter_square_mult.sv
// Top: combinational unsigned multiplier using the quarter-squares identity.
module quarter_square_mult
  import qsq_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] product
);

  qsqCtl_t ctl;

  qsq_order_ctl #(.OP_W(OP_W)) u_ctl (
    .opA(opA),
    .opB(opB),
    .ctl(ctl)
  );

  qsq_datapath #(.OP_W(OP_W)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .ctl    (ctl),
    .product(product)
  );

endmodule

// File: tb/quarter_square_mult_test.sv
`timescale 1ns/1ps
module quarter_square_mult_test;

  localparam int OP_W   = 8;
  localparam int NVEC   = 12;
  localparam int WD_CYC = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [OP_W-1:0]   opA = '0;
  logic [OP_W-1:0]   opB = '0;
  logic [2*OP_W-1:0] product;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  quarter_square_mult #(.OP_W(OP_W)) uut (
    .opA(opA),
    .opB(opB),
    .product(product)
  );

  // Directed vectors: operand A, operand B, expected product, requirement number.
  localparam logic [7:0]  vecA   [NVEC] = '{8'd0, 8'd0, 8'd255, 8'd255, 8'd1, 8'd200,
                                            8'd128, 8'd17, 8'd3, 8'd170, 8'd254, 8'd100};
  localparam logic [7:0]  vecB   [NVEC] = '{8'd0, 8'd255, 8'd0, 8'd255, 8'd200, 8'd1,
                                            8'd128, 8'd3, 8'd17, 8'd85, 8'd255, 8'd100};
  localparam logic [15:0] vecExp [NVEC] = '{16'd0, 16'd0, 16'd0, 16'd65025, 16'd200, 16'd200,
                                            16'd16384, 16'd51, 16'd51, 16'd14450, 16'd64770, 16'd10000};
  localparam int          vecReq [NVEC] = '{2, 2, 2, 5, 6, 6, 3, 4, 4, 1, 1, 3};

  function automatic string reqName(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [2*OP_W-1:0] got,
                       input logic [2*OP_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, opA, opB, got, exp);
    end
  endtask

  initial begin
    // Reset-time state: zero operands give zero product (R2)
    #1;
    check("R2", product, '0);
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      opA = vecA[v];
      opB = vecB[v];
      #1;
      check(reqName(vecReq[v]), product, vecExp[v]);
    end

    // R1: exhaustive comparison against the built-in multiply
    for (int a = 0; a < 2 ** OP_W; a++) begin
      for (int b = 0; b < 2 ** OP_W; b++) begin
        opA = OP_W'(a);
        opB = OP_W'(b);
        #1;
        check("R1", product, (2*OP_W)'(a * b));
      end
    end

    // R4: mirrored pairs agree
    for (int k = 0; k < 64; k++) begin
      logic [2*OP_W-1:0] fwd;
      opA = OP_W'(k * 37 + 5);
      opB = OP_W'(k * 11 + 200);
      #1;
      fwd = product;
      opA = OP_W'(k * 11 + 200);
      opB = OP_W'(k * 37 + 5);
      #1;
      check("R4", product, fwd);
    end

    // R7: output follows inputs between clock edges, no edge needed
    @(posedge clk);
    #0.5;
    opA = 8'd13;
    opB = 8'd19;
    #0.5;
    check("R7", product, 16'd247);
    opA = 8'd250;
    #0.5;
    check("R7", product, 16'd4750);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule